// File: doc/BRIEF.md
# Nibble-Loaded Cartridge Bank Register File

This block holds the bank-selection state of a cartridge memory controller in one of its personalities. A CPU write port (strobe, 16-bit address, 8-bit data) loads eight 1 KB pattern-bank registers four bits at a time. An arithmetic decode of the address picks the register and the nibble half. Two 8 KB program-bank registers and a mirroring register are loaded as whole bytes. The last two program pages are fixed to the top of program memory.

The outputs are four program page numbers and eight 9-bit pattern page numbers. The top bit of each pattern page is an outer-bank bit that comes from a separate input. A single bit selects the nametable mirroring. A mode-enable input decides whether CPU writes reach this personality. When it is low, every write is ignored.

Top module: `nbr_bank_ctl`

## Requirements
- R1: After reset, pattern registers 0..3 hold 0xFF and registers 4..7 hold their own index (4..7). Program banks 0 and 1 hold 0 and 1. The mirroring register and the outer-bank bit hold 0.
- R2: A pattern-register write is taken only when the address is between 0xB000 and 0xE003 inclusive. Only data bits 3:0 are stored; data bits 7:4 have no effect.
- R3: The pattern register written is index = ((((addr & 2) | (addr >> 10)) >> 1) + 2) mod 8, computed on the 16-bit address.
- R4: Address bit 0 = 0 writes bits 3:0 of the selected register, and address bit 0 = 1 writes bits 7:4. The other nibble keeps its value.
- R5: Outside the pattern range, address bits 15:12 select the target. 0x8 loads program bank 0, 0xA loads program bank 1, and 0x9 loads the mirroring register, each with the full data byte. Any other address changes no state.
- R6: Program page outputs 0 and 1 show program banks 0 and 1. Page outputs 2 and 3 are always PRG_PAGES-2 and PRG_PAGES-1.
- R7: mirror_horiz_o equals bit 0 of the mirroring register: 1 selects horizontal and 0 selects vertical.
- R8: Pattern page output i is {outer_q, reg[i]}, where outer_q is the outer_bank_i input registered on each clock edge.
- R9: While mode_en_i is low, a write strobe changes no register.
- R10: A write whose strobe is sampled on a rising edge is visible at the outputs right after that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_en_i | input | 1 | Personality enable; gates all writes |
| outer_bank_i | input | 1 | Outer-bank bit for the pattern pages |
| wr_en_i | input | 1 | CPU write strobe |
| wr_addr_i | input | 16 | CPU write address |
| wr_data_i | input | 8 | CPU write data |
| prg_page_o | output | 4x8 | Program page numbers, slots 0..3 |
| chr_page_o | output | 8x9 | Pattern page numbers with the outer bit at bit 8 |
| mirror_horiz_o | output | 1 | 1 = horizontal mirroring, 0 = vertical |

## Verification
The bench builds the block with PRG_PAGES = 16, so the expected fixed pages are 14 and 15. The register widths keep their defaults, so the full address decode is covered. A write to every address from 0x7F00 to 0xF0FF, with data that varies per address, is compared against an arithmetic model after each write. This reaches both edges of the pattern range, every index and nibble produced by the decode, and every top-nibble target. Separate passes cover the gate, the outer bit and the one-edge latency.

// File: rtl/nbr_pkg.sv
package nbr_pkg;
    typedef enum logic [2:0] {
        WK_NONE = 3'd0,
        WK_CHR  = 3'd1,
        WK_PRG0 = 3'd2,
        WK_PRG1 = 3'd3,
        WK_MIR  = 3'd4
    } wr_kind_e;
endpackage

// File: rtl/nbr_wr_decode.sv
module nbr_wr_decode
    import nbr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 3,
    parameter logic [ADDR_W-1:0] CHR_LO = 16'hB000,
    parameter logic [ADDR_W-1:0] CHR_HI = 16'hE003
) (
    input  logic              wr_en,
    input  logic              mode_en,
    input  logic [ADDR_W-1:0] addr,
    output wr_kind_e          kind,
    output logic [IDX_W-1:0]  idx,
    output logic              hi
);
    localparam int TOP_W = 4;

    logic [ADDR_W-1:0] idx_full;
    logic [TOP_W-1:0]  top;
    logic              in_chr;

    always_comb begin
        // R3: arithmetic index decode
        idx_full = ((((addr & ADDR_W'(2)) | (addr >> 10)) >> 1) + ADDR_W'(2));
        idx      = idx_full[IDX_W-1:0];
        hi       = addr[0];  // R4
        top      = addr[ADDR_W-1 -: TOP_W];
        in_chr   = (addr >= CHR_LO) && (addr <= CHR_HI);  // R2
        kind     = WK_NONE;
        if (wr_en && mode_en) begin  // R9
            if (in_chr) begin
                kind = WK_CHR;
            end else begin
                unique case (top)
                    4'h8:    kind = WK_PRG0;
                    4'hA:    kind = WK_PRG1;
                    4'h9:    kind = WK_MIR;
                    default: kind = WK_NONE;
                endcase
            end
        end
    end

    always_comb begin
        a_r9_gate_decode : assert (mode_en || kind == WK_NONE);
    end
endmodule

// File: rtl/nbr_chr_file.sv
module nbr_chr_file #(
    parameter int NREG  = 8,
    parameter int REG_W = 8,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [IDX_W-1:0]            idx,
    input  logic                        hi,
    input  logic [REG_W/2-1:0]          nib,
    output logic [NREG-1:0][REG_W-1:0]  regs_o
);
    localparam int NIB_W = REG_W / 2;
    localparam int HALF  = NREG / 2;

    typedef struct packed {
        logic [NREG-1:0][REG_W-1:0] bank;
    } chr_state_t;

    chr_state_t st_d, st_q;

    function automatic chr_state_t reset_state();
        chr_state_t s;
        for (int i = 0; i < NREG; i++) begin
            s.bank[i] = (i < HALF) ? {REG_W{1'b1}} : REG_W'(i);  // R1
        end
        return s;
    endfunction

    always_comb begin
        st_d = st_q;
        if (we) begin
            if (hi) st_d.bank[idx][REG_W-1 -: NIB_W] = nib;  // R4 high half
            else    st_d.bank[idx][NIB_W-1:0]        = nib;  // R4 low half
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end

    assign regs_o = st_q.bank;

    a_r9_hold_when_idle : assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(st_q));

    for (genvar g = 0; g < NREG; g++) begin : g_chk
        a_r4_high_kept : assert property (@(posedge clk) disable iff (!rst_n)
            (we && idx == IDX_W'(g) && !hi) |=>
            st_q.bank[g][REG_W-1 -: NIB_W] == $past(st_q.bank[g][REG_W-1 -: NIB_W]));
        a_r4_low_kept : assert property (@(posedge clk) disable iff (!rst_n)
            (we && idx == IDX_W'(g) && hi) |=>
            st_q.bank[g][NIB_W-1:0] == $past(st_q.bank[g][NIB_W-1:0]));
        a_r3_other_regs_kept : assert property (@(posedge clk) disable iff (!rst_n)
            (we && idx != IDX_W'(g)) |=> $stable(st_q.bank[g]));
    end
endmodule

// File: rtl/nbr_byte_regs.sv
module nbr_byte_regs
    import nbr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_kind_e          kind,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] prg0_o,
    output logic [DATA_W-1:0] prg1_o,
    output logic              mirror_o
);
    typedef struct packed {
        logic [DATA_W-1:0] prg0;
        logic [DATA_W-1:0] prg1;
        logic [DATA_W-1:0] mir;
    } byte_state_t;

    byte_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (kind)
            WK_PRG0: st_d.prg0 = data;  // R5
            WK_PRG1: st_d.prg1 = data;
            WK_MIR:  st_d.mir  = data;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.prg0 <= '0;            // R1
            st_q.prg1 <= DATA_W'(1);
            st_q.mir  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prg0_o   = st_q.prg0;
    assign prg1_o   = st_q.prg1;
    assign mirror_o = st_q.mir[0];  // R7

    a_r5_prg0_load : assert property (@(posedge clk) disable iff (!rst_n)
        (kind == WK_PRG0) |=> st_q.prg0 == $past(data));
    a_r5_prg1_load : assert property (@(posedge clk) disable iff (!rst_n)
        (kind == WK_PRG1) |=> st_q.prg1 == $past(data));
    a_r5_mir_load : assert property (@(posedge clk) disable iff (!rst_n)
        (kind == WK_MIR) |=> st_q.mir == $past(data));
    a_r5_no_stray : assert property (@(posedge clk) disable iff (!rst_n)
        (kind == WK_NONE || kind == WK_CHR) |=> $stable(st_q));
endmodule

// File: rtl/nbr_bank_ctl.sv
module nbr_bank_ctl
    import nbr_pkg::*;
#(
    parameter int PRG_PAGES = 64,
    parameter int PRG_W     = 8,
    parameter int NCHR      = 8,
    parameter int CHR_REG_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            mode_en_i,
    input  logic                            outer_bank_i,
    input  logic                            wr_en_i,
    input  logic [15:0]                     wr_addr_i,
    input  logic [PRG_W-1:0]                wr_data_i,
    output logic [3:0][PRG_W-1:0]           prg_page_o,
    output logic [NCHR-1:0][CHR_REG_W:0]    chr_page_o,
    output logic                            mirror_horiz_o
);
    localparam int ADDR_W = 16;
    localparam int IDX_W  = $clog2(NCHR);
    localparam int NIB_W  = CHR_REG_W / 2;
    localparam logic [PRG_W-1:0] PAGE_LAST2 = PRG_W'(PRG_PAGES - 2);
    localparam logic [PRG_W-1:0] PAGE_LAST1 = PRG_W'(PRG_PAGES - 1);

    wr_kind_e                        kind;
    logic [IDX_W-1:0]                idx;
    logic                            hi;
    logic [NCHR-1:0][CHR_REG_W-1:0]  chr_regs;
    logic [PRG_W-1:0]                prg0, prg1;
    logic                            mir;
    logic                            outer_d, outer_q;

    nbr_wr_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
        .wr_en   (wr_en_i),
        .mode_en (mode_en_i),
        .addr    (wr_addr_i),
        .kind    (kind),
        .idx     (idx),
        .hi      (hi)
    );

    nbr_chr_file #(.NREG(NCHR), .REG_W(CHR_REG_W), .IDX_W(IDX_W)) u_chr (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (kind == WK_CHR),
        .idx    (idx),
        .hi     (hi),
        .nib    (wr_data_i[NIB_W-1:0]),  // R2: low data bits only
        .regs_o (chr_regs)
    );

    nbr_byte_regs #(.DATA_W(PRG_W)) u_byte (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .data     (wr_data_i),
        .prg0_o   (prg0),
        .prg1_o   (prg1),
        .mirror_o (mir)
    );

    always_comb begin
        outer_d = outer_bank_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) outer_q <= 1'b0;
        else        outer_q <= outer_d;
    end

    always_comb begin
        prg_page_o[0] = prg0;
        prg_page_o[1] = prg1;
        prg_page_o[2] = PAGE_LAST2;  // R6
        prg_page_o[3] = PAGE_LAST1;
        for (int i = 0; i < NCHR; i++) begin
            chr_page_o[i] = {outer_q, chr_regs[i]};  // R8
        end
        mirror_horiz_o = mir;
    end

    a_r9_disabled_no_change : assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en_i |=> ($stable(chr_regs) && $stable(prg0) && $stable(prg1) && $stable(mir)));
    a_r8_outer_follows : assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> chr_page_o[0][CHR_REG_W] == $past(outer_bank_i));
    a_r2_out_of_range_chr_kept : assert property (@(posedge clk) disable iff (!rst_n)
        (wr_addr_i < 16'hB000 || wr_addr_i > 16'hE003) |=> $stable(chr_regs));
endmodule

// File: tb/nbr_bank_ctl_tb_top.sv
module nbr_bank_ctl_tb_top;
    localparam int PRG_PAGES = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_en = 1'b0;
    logic outer = 1'b0;
    logic wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [3:0][7:0] prg_page;
    logic [7:0][8:0] chr_page;
    logic mirror;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] m_chr [8];
    logic [7:0] m_prg0, m_prg1, m_mir;
    logic       m_outer;

    always #2 clk = ~clk;

    nbr_bank_ctl #(.PRG_PAGES(PRG_PAGES)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_en_i(mode_en), .outer_bank_i(outer),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .prg_page_o(prg_page), .chr_page_o(chr_page), .mirror_horiz_o(mirror)
    );

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_chr[i] = (i < 4) ? 8'hFF : 8'(i);
        m_prg0 = 8'd0; m_prg1 = 8'd1; m_mir = 8'd0; m_outer = 1'b0;
    endtask

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        int ix;
        if (!mode_en) return;
        if (a >= 16'hB000 && a <= 16'hE003) begin
            ix = ((((int'(a) & 2) | (int'(a) >> 10)) >> 1) + 2) % 8;
            if (a[0]) m_chr[ix][7:4] = d[3:0];
            else      m_chr[ix][3:0] = d[3:0];
        end else begin
            case (a[15:12])
                4'h8: m_prg0 = d;
                4'hA: m_prg1 = d;
                4'h9: m_mir  = d;
                default: ;
            endcase
        end
    endtask

    task automatic check_all(input string tag);
        bit bad = 1'b0;
        logic [7:0] exp_p [4];
        exp_p[0] = m_prg0; exp_p[1] = m_prg1;
        exp_p[2] = 8'(PRG_PAGES - 2); exp_p[3] = 8'(PRG_PAGES - 1);
        checks++;
        for (int i = 0; i < 4; i++) begin
            if (prg_page[i] !== exp_p[i]) begin
                bad = 1'b1;
                $display("FAIL %s prg_page[%0d] actual=%h expected=%h", tag, i, prg_page[i], exp_p[i]);
            end
        end
        for (int i = 0; i < 8; i++) begin
            if (chr_page[i] !== {m_outer, m_chr[i]}) begin
                bad = 1'b1;
                $display("FAIL %s chr_page[%0d] actual=%h expected=%h", tag, i, chr_page[i], {m_outer, m_chr[i]});
            end
        end
        if (mirror !== m_mir[0]) begin
            bad = 1'b1;
            $display("FAIL %s mirror actual=%b expected=%b", tag, mirror, m_mir[0]);
        end
        if (bad) failures++;
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        model_write(a, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset state");
        check_all("R6 fixed pages at reset");

        // R9: writes with the gate low change nothing
        mode_en = 1'b0;
        do_write(16'hB000, 8'h05);
        do_write(16'h8000, 8'h33);
        do_write(16'h9000, 8'h01);
        do_write(16'hA000, 8'h44);
        check_all("R9 gated writes ignored");

        mode_en = 1'b1;
        // R10: not visible before the edge, visible right after it
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 16'h8000; wr_data = 8'h5A;
        #1;
        check_all("R10 before edge");
        model_write(16'h8000, 8'h5A);
        @(posedge clk); #1;
        wr_en = 1'b0;
        check_all("R10 after edge");

        // R7 mirror both senses
        do_write(16'h9123, 8'hFF); @(negedge clk); check_all("R7 horizontal");
        do_write(16'h9000, 8'hFE); @(negedge clk); check_all("R7 vertical");

        // R4 nibble halves on register 0, R2 upper data bits dropped
        do_write(16'hB000, 8'hA3); @(negedge clk); check_all("R2 R4 low nibble");
        do_write(16'hB001, 8'h7C); @(negedge clk); check_all("R4 high nibble");

        // R8 outer bit
        @(negedge clk); outer = 1'b1; m_outer = 1'b1;
        @(negedge clk); check_all("R8 outer set");
        @(negedge clk); outer = 1'b0; m_outer = 1'b0;
        @(negedge clk); check_all("R8 outer clear");

        // R2 R3 R5: sweep across and around the decoded window
        for (int a = 'h7F00; a <= 'hF0FF; a++) begin
            logic [15:0] aw;
            logic [7:0] dv;
            aw = 16'(a);
            dv = aw[7:0] ^ aw[15:8] ^ {aw[3:0], aw[7:4]} ^ 8'h96;
            do_write(aw, dv);
            if (aw >= 16'hB000 && aw <= 16'hE003) check_all("R3 R4 sweep in range");
            else check_all("R2 R5 sweep out of range");
            if (aw == 16'hC000) begin
                @(negedge clk); outer = 1'b1; m_outer = 1'b1;
                @(negedge clk); check_all("R8 outer mid sweep");
            end
        end
        check_all("R6 fixed pages after sweep");
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d cycles expected=completion", cyc);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule